// File: doc/BRIEF.md
# Nanosecond Real-Time Clock with Alarm

This peripheral keeps a free-running 64-bit nanosecond counter and a 64-bit alarm deadline behind a small 32-bit register bus. Each cycle in which the `tick` input is high, the counter advances by a fixed step of `STEP_NS` nanoseconds. Software can read the counter as two halves. It can also overwrite either half while the counter keeps running.

Software programs the alarm in two steps. It first stores the upper half of the deadline. It then writes the lower half, and that write arms the alarm. If the deadline is already due at that moment, the alarm fires at once. Otherwise the block compares the running count against the deadline on every cycle and fires when the count reaches or passes it. A firing raises a pending flag. The level interrupt output is that flag gated by a software enable bit.

A read of the lower counter half also captures the upper half into a holding register. A later read of the upper half returns that captured value, so a low-then-high read pair always forms one coherent 64-bit sample. Every access takes a single cycle, and read data is combinational while the read strobe is high.

Top module: `nano_rtc`

## Requirements
- R1: After reset, reads of the counter halves (0x00, 0x04), the alarm halves (0x08, 0x0C), the enable register (0x10) and the armed status (0x18) all return zero, and `irq` is low.
- R2: The counter grows by `STEP_NS` at every clock edge where `tick` is high, and holds its value at edges where `tick` is low and no counter half is written.
- R3: A read of 0x00 returns counter bits 31:0 and copies bits 63:32 into a holding register. A read of 0x04 returns that holding register, not the live upper half.
- R4: A write to 0x00 or 0x04 replaces only bits 31:0 or bits 63:32 of the counter. If `tick` is high in the same cycle, the other half takes its advanced value.
- R5: A write to 0x0C stores alarm bits 63:32 and does not arm the alarm. The armed status at 0x18 bit 0 stays 0.
- R6: A write to 0x08 stores alarm bits 31:0 and arms the alarm. If the new deadline is strictly greater than the current count, the armed status reads 1.
- R7: If a write to 0x08 makes the deadline less than or equal to the current count, the pending flag is set at that edge and the armed status stays 0.
- R8: While armed, once the count is greater than or equal to the deadline, the next edge clears the armed flag and sets the pending flag. This holds even when the step jumps past the exact deadline.
- R9: `irq` is high exactly when the pending flag and the enable bit are both set. Only bit 0 of a write to 0x10 is kept, and a read of 0x10 returns it in bit 0.
- R10: Any write to 0x14 clears the armed flag and leaves the pending flag and the stored deadline alone. Any write to 0x1C clears the pending flag. Both ignore the write data.
- R11: Reads of the write-only offsets 0x14 and 0x1C, and of any unmapped address, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Advance the counter by STEP_NS on this edge |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe; rdata valid in the same cycle |
| bus_rdata | output | 32 | Read data, zero when bus_re is low |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The hardest condition to reach from the ports is a coherent read across a carry out of the lower counter half. It needs a captured upper half that differs from the live one. The bench loads the counter a few steps below a 32-bit wrap and reads the lower half to capture the upper half. It then ticks across the wrap and reads the upper half, which must still show the old value. An alarm whose deadline the step overshoots is reached by choosing a deadline that is not a multiple of the step. A deadline equal to the current count is reached by loading the count with tick held low and writing that same value as the alarm's lower half.

// File: rtl/nano_rtc_pkg.sv
// Package: register offsets and the decoded access strobes shared by the
// clock, alarm and checker logic. Offsets are byte addresses on a 32-bit bus.
package nano_rtc_pkg;

    localparam logic [7:0] OFS_TIME_LO  = 8'h00;
    localparam logic [7:0] OFS_TIME_HI  = 8'h04;
    localparam logic [7:0] OFS_ALARM_LO = 8'h08;
    localparam logic [7:0] OFS_ALARM_HI = 8'h0C;
    localparam logic [7:0] OFS_ENABLE   = 8'h10;
    localparam logic [7:0] OFS_DISARM   = 8'h14;
    localparam logic [7:0] OFS_ARMED    = 8'h18;
    localparam logic [7:0] OFS_ACK      = 8'h1C;

    // One-hot per-cycle access strobes produced by the decoder.
    typedef struct packed {
        logic wr_time_lo;
        logic wr_time_hi;
        logic wr_alarm_lo;
        logic wr_alarm_hi;
        logic wr_enable;
        logic wr_disarm;
        logic wr_ack;
        logic rd_time_lo;
    } strobe_t;

endpackage

// File: rtl/nano_rtc_decode.sv
// Module: nano_rtc_decode
// Turns the bus address and strobes into one-hot access strobes.
// Assumes word-aligned byte addresses; any other address matches nothing.
module nano_rtc_decode
    import nano_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    output strobe_t           strb
);

    // Purpose: compare the address against each side-effecting offset.
    always_comb begin
        strb             = '0;
        strb.wr_time_lo  = bus_we && (bus_addr == ADDR_W'(OFS_TIME_LO));
        strb.wr_time_hi  = bus_we && (bus_addr == ADDR_W'(OFS_TIME_HI));
        strb.wr_alarm_lo = bus_we && (bus_addr == ADDR_W'(OFS_ALARM_LO));
        strb.wr_alarm_hi = bus_we && (bus_addr == ADDR_W'(OFS_ALARM_HI));
        strb.wr_enable   = bus_we && (bus_addr == ADDR_W'(OFS_ENABLE));
        strb.wr_disarm   = bus_we && (bus_addr == ADDR_W'(OFS_DISARM));
        strb.wr_ack      = bus_we && (bus_addr == ADDR_W'(OFS_ACK));
        strb.rd_time_lo  = bus_re && (bus_addr == ADDR_W'(OFS_TIME_LO));
    end

endmodule

// File: rtl/nano_rtc_counter.sv
// Module: nano_rtc_counter
// Free-running nanosecond counter split into NHALF bus-width slices.
// Every slice can be overwritten on its own. A slice write beats the tick,
// and the other slices keep their advanced value. Reset clears the count.
module nano_rtc_counter #(
    parameter int unsigned HALF_W  = 32,
    parameter int unsigned NHALF   = 2,
    parameter int unsigned STEP_NS = 10,
    localparam int unsigned CNT_W  = HALF_W * NHALF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NHALF-1:0]  wr_half,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_adv;
    logic [CNT_W-1:0] cnt_next;

    // Purpose: value the counter would take from the tick alone.
    always_comb begin
        cnt_adv = cnt_q + (tick ? CNT_W'(STEP_NS) : '0);
    end

    // Purpose: per-slice choice between written data and advanced value.
    for (genvar h = 0; h < NHALF; h++) begin : g_slice
        assign cnt_next[h*HALF_W +: HALF_W] =
            wr_half[h] ? wdata : cnt_adv[h*HALF_W +: HALF_W];
    end

    // Purpose: counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    assign count = cnt_q;

endmodule

// File: rtl/nano_rtc_alarm.sv
// Module: nano_rtc_alarm
// Holds the deadline, the armed and pending flags and the interrupt enable.
// Arming happens on the lower-half write and compares against the count
// held before that edge. Match uses >=, so a step larger than 1 cannot skip
// the deadline. A match in the same cycle as an acknowledge wins, so no
// event is lost.
module nano_rtc_alarm #(
    parameter int unsigned HALF_W = 32,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_enable,
    input  logic              wr_disarm,
    input  logic              wr_ack,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  deadline,
    output logic              armed,
    output logic              pending,
    output logic              enable,
    output logic              irq
);

    logic [CNT_W-1:0] dl_q;
    logic             armed_q, pend_q, en_q;
    logic             armed_n, pend_n;
    logic [CNT_W-1:0] arm_val;
    logic             hit;

    // Purpose: deadline as it becomes once the lower-half write lands.
    assign arm_val = {dl_q[CNT_W-1:HALF_W], wdata};
    assign hit     = armed_q && (count >= dl_q);

    // Purpose: next state of the flags; later statements take priority.
    always_comb begin
        armed_n = armed_q;
        pend_n  = pend_q;
        if (wr_ack)    pend_n  = 1'b0;
        if (hit) begin
            armed_n = 1'b0;
            pend_n  = 1'b1;
        end
        if (wr_disarm) armed_n = 1'b0;
        if (wr_lo) begin
            if (arm_val <= count) begin
                armed_n = 1'b0;
                pend_n  = 1'b1;
            end else begin
                armed_n = 1'b1;
            end
        end
    end

    // Purpose: deadline halves, enable bit and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_q    <= '0;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            if (wr_lo)     dl_q[HALF_W-1:0]     <= wdata;
            if (wr_hi)     dl_q[CNT_W-1:HALF_W] <= wdata;
            if (wr_enable) en_q                 <= wdata[0];
            armed_q <= armed_n;
            pend_q  <= pend_n;
        end
    end

    assign deadline = dl_q;
    assign armed    = armed_q;
    assign pending  = pend_q;
    assign enable   = en_q;
    assign irq      = pend_q & en_q;

endmodule

// File: rtl/nano_rtc.sv
// Module: nano_rtc (top)
// Register-bus real-time clock with a single alarm and a level interrupt.
// Assumes one access per cycle (bus_we and bus_re never high together) and
// a 32-bit data bus. Read data is combinational from registered state.
module nano_rtc
    import nano_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned STEP_NS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int unsigned HALF_W = 32;
    localparam int unsigned NHALF  = 2;
    localparam int unsigned CNT_W  = HALF_W * NHALF;

    strobe_t           strb;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  alarm_q;
    logic              armed_q, pend_q, en_q;
    logic [HALF_W-1:0] hold_q;

    nano_rtc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .strb     (strb)
    );

    nano_rtc_counter #(.HALF_W(HALF_W), .NHALF(NHALF), .STEP_NS(STEP_NS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_half ({strb.wr_time_hi, strb.wr_time_lo}),
        .wdata   (bus_wdata),
        .count   (cnt_q)
    );

    nano_rtc_alarm #(.HALF_W(HALF_W)) u_alm (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (cnt_q),
        .wr_lo     (strb.wr_alarm_lo),
        .wr_hi     (strb.wr_alarm_hi),
        .wr_enable (strb.wr_enable),
        .wr_disarm (strb.wr_disarm),
        .wr_ack    (strb.wr_ack),
        .wdata     (bus_wdata),
        .deadline  (alarm_q),
        .armed     (armed_q),
        .pending   (pend_q),
        .enable    (en_q),
        .irq       (irq)
    );

    // Purpose: capture the upper count half whenever the lower half is read.
    always_ff @(posedge clk) begin
        if (!rst_n)               hold_q <= '0;
        else if (strb.rd_time_lo) hold_q <= cnt_q[CNT_W-1:HALF_W];
    end

    // Purpose: read multiplexer; write-only and unmapped offsets give zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                ADDR_W'(OFS_TIME_LO):  bus_rdata = cnt_q[HALF_W-1:0];
                ADDR_W'(OFS_TIME_HI):  bus_rdata = hold_q;
                ADDR_W'(OFS_ALARM_LO): bus_rdata = alarm_q[HALF_W-1:0];
                ADDR_W'(OFS_ALARM_HI): bus_rdata = alarm_q[CNT_W-1:HALF_W];
                ADDR_W'(OFS_ENABLE):   bus_rdata = {31'd0, en_q};
                ADDR_W'(OFS_ARMED):    bus_rdata = {31'd0, armed_q};
                default:               bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/nano_rtc_chk.sv
// Module: nano_rtc_chk
// Property checker attached to nano_rtc by bind. It watches the bus ports
// together with the counter, deadline and flags inside the top.
module nano_rtc_chk
    import nano_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned HALF_W = 32,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  alarm,
    input logic              armed,
    input logic              pending
);

    // R2: no tick and no write means the counter holds.
    assert_count_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bus_we) |=> (count == $past(count)));

    // R5: storing the upper deadline half never arms.
    assert_hi_no_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_ALARM_HI) && !armed) |=> !armed);

    // R7: arming with a deadline already due fires without arming.
    assert_due_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_ALARM_LO)
         && ({alarm[CNT_W-1:HALF_W], bus_wdata} <= count))
        |=> (pending && !armed));

    // R8: an armed alarm that is reached fires on the next edge.
    assert_match_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && count >= alarm && !bus_we) |=> (pending && !armed));

    // R10: the disarm write always leaves the alarm disarmed.
    assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_DISARM)) |=> !armed);

    // R10: acknowledge without a simultaneous match drops the interrupt.
    assert_ack_drops_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_ACK) && !(armed && count >= alarm))
        |=> !irq);

    // R11: reading the write-only offsets yields zero.
    assert_wo_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (bus_addr == ADDR_W'(OFS_DISARM) || bus_addr == ADDR_W'(OFS_ACK)))
        |-> (bus_rdata == 32'd0));

endmodule

bind nano_rtc nano_rtc_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count     (cnt_q),
    .alarm     (alarm_q),
    .armed     (armed_q),
    .pending   (pend_q)
);

// File: tb/nano_rtc_test.sv
// Directed bench for nano_rtc: one task per scenario, each checking itself.
// Inputs change 1 ns after a rising edge; outputs are sampled mid-cycle or
// 1 ns after an edge, never on it.
module nano_rtc_test;

    localparam int unsigned ADDR_W = 6;
    localparam int unsigned STEP   = 10;

    localparam logic [5:0] A_TLO  = 6'h00;
    localparam logic [5:0] A_THI  = 6'h04;
    localparam logic [5:0] A_ALO  = 6'h08;
    localparam logic [5:0] A_AHI  = 6'h0C;
    localparam logic [5:0] A_EN   = 6'h10;
    localparam logic [5:0] A_CLRA = 6'h14;
    localparam logic [5:0] A_STAT = 6'h18;
    localparam logic [5:0] A_CLRI = 6'h1C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nano_rtc #(.ADDR_W(ADDR_W), .STEP_NS(STEP)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic tk = 1'b0);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick = tk;
        @(posedge clk); #1;
        bus_we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #4 d = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_TLO, v);  chk("R1", "time lo", v, 0);
        rd(A_THI, v);  chk("R1", "time hi", v, 0);
        rd(A_ALO, v);  chk("R1", "alarm lo", v, 0);
        rd(A_AHI, v);  chk("R1", "alarm hi", v, 0);
        rd(A_EN, v);   chk("R1", "enable", v, 0);
        rd(A_STAT, v); chk("R1", "armed", v, 0);
        chk("R1", "irq", {31'd0, irq}, 0);
    endtask

    task automatic t_tick();
        logic [31:0] v;
        wr(A_TLO, 100);
        ticks(5);
        rd(A_TLO, v); chk("R2", "after 5 ticks", v, 100 + 5 * STEP);
        repeat (3) idle();
        rd(A_TLO, v); chk("R2", "hold without tick", v, 100 + 5 * STEP);
    endtask

    task automatic t_latch();
        logic [31:0] v;
        wr(A_THI, 32'h12);
        wr(A_TLO, 32'hFFFF_FFF0);
        rd(A_TLO, v); chk("R3", "lo before wrap", v, 32'hFFFF_FFF0);
        ticks(2);
        rd(A_THI, v); chk("R3", "hi is captured value", v, 32'h12);
        rd(A_TLO, v); chk("R3", "lo after wrap", v, 32'h4);
        rd(A_THI, v); chk("R3", "hi after recapture", v, 32'h13);
    endtask

    task automatic t_halfwrite();
        logic [31:0] v;
        wr(A_THI, 5);
        wr(A_TLO, 7);
        wr(A_TLO, 32'hAAAA, 1'b1);
        wr(A_THI, 9, 1'b1);
        rd(A_TLO, v); chk("R4", "lo ticked after hi write", v, 32'hAAAA + STEP);
        rd(A_THI, v); chk("R4", "hi written", v, 9);
    endtask

    task automatic t_alarm_hi();
        logic [31:0] v;
        wr(A_AHI, 3);
        rd(A_STAT, v); chk("R5", "not armed by hi write", v, 0);
        rd(A_AHI, v);  chk("R5", "hi stored", v, 3);
        rd(A_ALO, v);  chk("R5", "lo untouched", v, 0);
    endtask

    task automatic t_arm_future();
        logic [31:0] v;
        wr(A_TLO, 0); wr(A_THI, 0);
        wr(A_EN, 1);
        wr(A_AHI, 0);
        wr(A_ALO, 50);
        rd(A_STAT, v); chk("R6", "armed", v, 1);
        chk("R6", "irq before deadline", {31'd0, irq}, 0);
        ticks(4);
        rd(A_STAT, v); chk("R8", "still armed at 40", v, 1);
        chk("R8", "irq at 40", {31'd0, irq}, 0);
        ticks(1);
        idle();
        chk("R8", "irq after reaching 50", {31'd0, irq}, 1);
        rd(A_STAT, v); chk("R8", "disarmed after fire", v, 0);
    endtask

    task automatic t_overshoot();
        logic [31:0] v;
        wr(A_CLRI, 0);
        chk("R10", "ack clears irq", {31'd0, irq}, 0);
        wr(A_ALO, 55);
        rd(A_STAT, v); chk("R6", "armed at 55", v, 1);
        ticks(1);
        idle();
        chk("R8", "fires past deadline", {31'd0, irq}, 1);
        rd(A_TLO, v); chk("R2", "count at 60", v, 60);
    endtask

    task automatic t_past();
        logic [31:0] v;
        wr(A_CLRI, 0);
        wr(A_TLO, 1000);
        wr(A_ALO, 500);
        chk("R7", "past deadline irq", {31'd0, irq}, 1);
        rd(A_STAT, v); chk("R7", "past deadline not armed", v, 0);
        wr(A_CLRI, 0);
        chk("R10", "ack clears irq", {31'd0, irq}, 0);
        wr(A_ALO, 1000);
        chk("R7", "equal deadline irq", {31'd0, irq}, 1);
        rd(A_STAT, v); chk("R7", "equal deadline not armed", v, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(A_EN, 32'hFFFF_FFFE);
        chk("R9", "irq masked", {31'd0, irq}, 0);
        rd(A_EN, v); chk("R9", "only bit0 kept", v, 0);
        wr(A_EN, 3);
        rd(A_EN, v); chk("R9", "enable reads 1", v, 1);
        chk("R9", "irq unmasked", {31'd0, irq}, 1);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(A_ALO, 100000);
        rd(A_STAT, v); chk("R6", "armed far", v, 1);
        chk("R10", "pending kept across arm", {31'd0, irq}, 1);
        wr(A_CLRA, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R10", "disarmed", v, 0);
        chk("R10", "pending kept by disarm", {31'd0, irq}, 1);
        rd(A_ALO, v); chk("R10", "deadline kept", v, 100000);
        wr(A_CLRI, 32'hFFFF_FFFF);
        chk("R10", "ack with data ones", {31'd0, irq}, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(A_CLRA, v);  chk("R11", "read 0x14", v, 0);
        rd(A_CLRI, v);  chk("R11", "read 0x1C", v, 0);
        rd(6'h20, v);   chk("R11", "read 0x20", v, 0);
        rd(6'h3C, v);   chk("R11", "read 0x3C", v, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        t_reset();
        t_tick();
        t_latch();
        t_halfwrite();
        t_alarm_hi();
        t_arm_future();
        t_overshoot();
        t_past();
        t_enable();
        t_clear();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule